// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the Type 0 configuration header for a function that sits behind a hard PCI target core. The core hands over each configuration write as a one-cycle strobe, a dword register index, a 32-bit data word and four active-low byte enables. For reads the core presents only the index, and the block drives the selected register onto its read-data bus in the same cycle, with no register stage. The index is eight bits wide, which covers the whole 1 KB configuration region. Only the first six dwords hold anything, and every other dword reads as zero.

The header holds these registers:
- Read-only identity and class fields, set by parameters.
- The Command and Status registers.
- Two base address registers. The first decodes memory space and the second decodes I/O space.

Four Command bits leave the block as plain outputs:
- The I/O enable and the memory enable, for address selection elsewhere.
- The parity-response bit and the system-error-enable bit, which go back to the core.

The core reports two bus errors as single-cycle event strobes: a parity error it detected and a system error it signalled. Each strobe sets a sticky Status bit, and software clears that bit by writing one to it.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset:
  - dword 1 reads 0x00000000.
  - dword 4 reads 0x00000000.
  - dword 5 reads 0x00000001.
  - io_en, mem_en, parity_en and serr_en are all low.
- R2: Dword 0 reads {DEVICE_ID, VENDOR_ID} and dword 2 reads {CLASS_CODE, REVISION}. Writes to these two dwords change nothing.
- R3: In dword 1, the Command half (bits 15:0) has only bits 0, 1, 2, 6, 8 and 10 writable, and every other Command bit reads zero. The outputs follow those bits: io_en is bit 0, mem_en is bit 1, parity_en is bit 6 and serr_en is bit 8.
- R4: Bit n of cfg_be_n low enables byte n (data bits 8n+7:8n) of a write. Bytes whose enable is high keep their old value.
- R5: A one-cycle pulse on perr_evt sets dword 1 bit 31. A pulse on serr_evt sets dword 1 bit 30. Both bits stay set until they are cleared.
- R6: Writing a 1 to dword 1 bit 31 or bit 30, with byte 3 enabled, clears that bit. Writing a 0, or writing with byte 3 disabled, leaves the bit unchanged.
- R7: When a clear of a Status error bit and the set event for that same bit arrive in the same cycle, the bit ends up set.
- R8: Dword 4 is the memory BAR. Bits 31:MEM_BAR_BITS are writable, and bits MEM_BAR_BITS-1:0 read zero, including bit 0, which marks memory space.
- R9: Dword 5 is the I/O BAR. Bits 31:IO_BAR_BITS are writable, bits IO_BAR_BITS-1:1 read zero, and bit 0 always reads 1, which marks I/O space.
- R10: Dwords 3 and 6 through 255 read zero, and writes to them change no other register.
- R11: With cfg_wr low, the values on the data, index and byte-enable inputs change no register.
- R12: cfg_rdata shows the dword selected by cfg_idx in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Dword index into the configuration region |
| cfg_wdata | input | 32 | Write data |
| cfg_be_n | input | 4 | Active-low byte enables |
| cfg_rdata | output | 32 | Read data of the selected dword |
| perr_evt | input | 1 | Parity error detected, one-cycle event |
| serr_evt | input | 1 | System error signalled, one-cycle event |
| io_en | output | 1 | Command bit 0, I/O access enable |
| mem_en | output | 1 | Command bit 1, memory access enable |
| parity_en | output | 1 | Command bit 6, parity error response |
| serr_en | output | 1 | Command bit 8, system error enable |

## Verification
A software clear of a Status error bit and the core's event for that same bit can land in the same clock cycle. The bench provokes this by raising perr_evt in the cycle that carries a write of 1 to dword 1 bit 31 with byte 3 enabled. It then reads dword 1 back and expects bit 31 still set, as R7 requires. Before that, it shows that a plain clear does work, so the surviving bit is known to come from the event winning.

// File: rtl/cfg_hdr_pkg.sv
// Shared constants and helpers for the configuration header.
// Assumes dword indexing, so that index n covers byte offset 4*n.
package cfg_hdr_pkg;

    localparam int IDX_W = 8;

    localparam logic [IDX_W-1:0] IDX_ID      = 8'd0;
    localparam logic [IDX_W-1:0] IDX_CMDSTAT = 8'd1;
    localparam logic [IDX_W-1:0] IDX_CLASS   = 8'd2;
    localparam logic [IDX_W-1:0] IDX_BAR_MEM = 8'd4;
    localparam logic [IDX_W-1:0] IDX_BAR_IO  = 8'd5;

    // Writable Command bits: 0 I/O, 1 memory, 2 master, 6 parity, 8 SERR, 10 INTx off
    localparam logic [15:0] CMD_WMASK = 16'h0547;

    // Merge a new dword into an old one under active-low byte enables
    function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be_n);
        logic [31:0] r;
        r = old_v;
        for (int b = 0; b < 4; b++) begin
            if (!be_n[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_cmd_stat.sv
// Command register plus the two sticky Status error bits.
// Assumes wr_sel is already qualified with the write strobe and the index.
// Status error bits are write-one-to-clear, and a set event wins over a clear.
module cfg_cmd_stat
    import cfg_hdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  logic [31:0] wdata,
    input  logic [3:0]  be_n,
    input  logic        perr_evt,
    input  logic        serr_evt,
    output logic [15:0] cmd_q,
    output logic [1:0]  err_q      // [1] parity detected, [0] system error signalled
);

    logic [31:0] cmd_merged;
    logic        clr_perr;
    logic        clr_serr;

    // Byte-merge the Command half, keeping only the implemented bits
    always_comb begin
        cmd_merged = be_merge({16'h0000, cmd_q}, wdata, {2'b11, be_n[1:0]});
        clr_perr   = wr_sel && !be_n[3] && wdata[31];
        clr_serr   = wr_sel && !be_n[3] && wdata[30];
    end

    // Command register update
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (wr_sel) cmd_q <= cmd_merged[15:0] & CMD_WMASK;
    end

    // Sticky error bits: the event sets, a write of one clears, the event wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q[1] <= perr_evt | (err_q[1] & ~clr_perr);
            err_q[0] <= serr_evt | (err_q[0] & ~clr_serr);
        end
    end

endmodule

// File: rtl/cfg_bar.sv
// One 32-bit base address register.
// BASE_BITS sets the decoded size: bits below it read zero.
// IS_IO chooses I/O space (bit 0 reads 1) or memory space (bit 0 reads 0).
// Assumes BASE_BITS is at least 4 for memory and at least 2 for I/O.
module cfg_bar
    import cfg_hdr_pkg::*;
#(
    parameter int BASE_BITS = 12,
    parameter bit IS_IO     = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  logic [31:0] wdata,
    input  logic [3:0]  be_n,
    output logic [31:0] rd_val
);

    localparam logic [31:0] KEEP_MASK = ~((32'd1 << BASE_BITS) - 32'd1);

    logic [31:0] base_q;

    // Base address update, with the bits below the size forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (wr_sel) base_q <= be_merge(base_q, wdata, be_n) & KEEP_MASK;
    end

    generate
        if (IS_IO) begin : g_io
            // I/O space marker in bit 0
            always_comb rd_val = base_q | 32'd1;
        end else begin : g_mem
            // 32-bit, non-prefetchable memory: type bits read zero
            always_comb rd_val = base_q;
        end
    endgenerate

endmodule

// File: rtl/cfg_hdr_regs.sv
// Type 0 configuration header register file, top level.
// Decodes configuration writes by dword index and drives the selected
// dword combinationally. Unimplemented dwords read zero and ignore writes.
module cfg_hdr_regs
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID    = 16'h0420,
    parameter logic [7:0]  REVISION     = 8'h03,
    parameter logic [23:0] CLASS_CODE   = 24'h118000,
    parameter int          MEM_BAR_BITS = 12,
    parameter int          IO_BAR_BITS  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic [3:0]        cfg_be_n,
    output logic [31:0]       cfg_rdata,
    input  logic              perr_evt,
    input  logic              serr_evt,
    output logic              io_en,
    output logic              mem_en,
    output logic              parity_en,
    output logic              serr_en
);

    logic        sel_cmd;
    logic        sel_mem;
    logic        sel_io;
    logic [15:0] cmd_q;
    logic [1:0]  err_q;
    logic [31:0] bar_mem_rd;
    logic [31:0] bar_io_rd;

    // Write select per implemented register
    always_comb begin
        sel_cmd = cfg_wr && (cfg_idx == IDX_CMDSTAT);
        sel_mem = cfg_wr && (cfg_idx == IDX_BAR_MEM);
        sel_io  = cfg_wr && (cfg_idx == IDX_BAR_IO);
    end

    cfg_cmd_stat u_cmd_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (sel_cmd),
        .wdata    (cfg_wdata),
        .be_n     (cfg_be_n),
        .perr_evt (perr_evt),
        .serr_evt (serr_evt),
        .cmd_q    (cmd_q),
        .err_q    (err_q)
    );

    cfg_bar #(.BASE_BITS(MEM_BAR_BITS), .IS_IO(1'b0)) u_bar_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (sel_mem),
        .wdata  (cfg_wdata),
        .be_n   (cfg_be_n),
        .rd_val (bar_mem_rd)
    );

    cfg_bar #(.BASE_BITS(IO_BAR_BITS), .IS_IO(1'b1)) u_bar_io (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (sel_io),
        .wdata  (cfg_wdata),
        .be_n   (cfg_be_n),
        .rd_val (bar_io_rd)
    );

    // Read multiplexer: unimplemented dwords return zero
    always_comb begin
        case (cfg_idx)
            IDX_ID:      cfg_rdata = {DEVICE_ID, VENDOR_ID};
            IDX_CMDSTAT: cfg_rdata = {err_q, 14'h0000, cmd_q};
            IDX_CLASS:   cfg_rdata = {CLASS_CODE, REVISION};
            IDX_BAR_MEM: cfg_rdata = bar_mem_rd;
            IDX_BAR_IO:  cfg_rdata = bar_io_rd;
            default:     cfg_rdata = 32'h0000_0000;
        endcase
    end

    // Command bits exported to decode logic and to the core
    always_comb begin
        io_en     = cmd_q[0];
        mem_en    = cmd_q[1];
        parity_en = cmd_q[6];
        serr_en   = cmd_q[8];
    end

endmodule

// File: rtl/cfg_hdr_regs_chk.sv
// Assertion checker for cfg_hdr_regs, attached by bind.
// Watches the ports and the sticky Status error bits.
module cfg_hdr_regs_chk #(
    parameter int MEM_BAR_BITS = 12,
    parameter int IO_BAR_BITS  = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [7:0]  cfg_idx,
    input logic [31:0] cfg_rdata,
    input logic        perr_evt,
    input logic        serr_evt,
    input logic        io_en,
    input logic        mem_en,
    input logic        parity_en,
    input logic        serr_en,
    input logic [1:0]  err_q
);

    AST_PERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        perr_evt |=> err_q[1]);                                          // R7
    AST_SERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        serr_evt |=> err_q[0]);                                          // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && err_q[1]) |=> err_q[1]);                             // R6
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable({io_en, mem_en, parity_en, serr_en}));       // R11
    AST_MEM_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == 8'd4) |-> (cfg_rdata[MEM_BAR_BITS-1:0] == '0));      // R8
    AST_IO_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == 8'd5) |-> (cfg_rdata[0] && cfg_rdata[IO_BAR_BITS-1:1] == '0)); // R9
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == 8'd3 || cfg_idx > 8'd5) |-> (cfg_rdata == 32'd0));   // R10

endmodule

bind cfg_hdr_regs cfg_hdr_regs_chk #(
    .MEM_BAR_BITS(MEM_BAR_BITS),
    .IO_BAR_BITS (IO_BAR_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_idx   (cfg_idx),
    .cfg_rdata (cfg_rdata),
    .perr_evt  (perr_evt),
    .serr_evt  (serr_evt),
    .io_en     (io_en),
    .mem_en    (mem_en),
    .parity_en (parity_en),
    .serr_en   (serr_en),
    .err_q     (err_q)
);

// File: tb/tb_cfg_hdr_regs.sv
// Scoreboard bench: driver tasks queue expected read data, and a monitor
// compares it on the falling edge.
module tb_cfg_hdr_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_idx = 8'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [3:0]  cfg_be_n = 4'hF;
    logic [31:0] cfg_rdata;
    logic        perr_evt = 1'b0;
    logic        serr_evt = 1'b0;
    logic        io_en, mem_en, parity_en, serr_en;

    typedef struct {
        logic [7:0]  idx;
        logic [31:0] exp;
        string       req;
    } rd_item_t;

    rd_item_t sb_q[$];
    logic     rd_pend = 1'b0;
    int       n_run = 0;
    int       n_fail = 0;
    bit       done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cfg_hdr_regs dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_be_n(cfg_be_n), .cfg_rdata(cfg_rdata),
        .perr_evt(perr_evt), .serr_evt(serr_evt), .io_en(io_en),
        .mem_en(mem_en), .parity_en(parity_en), .serr_en(serr_en)
    );

    // Monitor: pop and compare one expected item per pending read
    always @(negedge clk) begin
        if (rd_pend && sb_q.size() > 0) begin
            rd_item_t it;
            it = sb_q.pop_front();
            n_run++;
            if (cfg_rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s idx=%0d actual=%h expected=%h", it.req, it.idx, cfg_rdata, it.exp);
            end
        end
    end

    task automatic cfg_write(input logic [7:0] idx, input logic [31:0] d,
                             input logic [3:0] be, input logic perr = 1'b0);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d; cfg_be_n = be; perr_evt = perr;
        @(posedge clk); #1;
        cfg_wr = 1'b0; perr_evt = 1'b0; cfg_be_n = 4'hF;
    endtask

    task automatic cfg_read(input logic [7:0] idx, input logic [31:0] e, input string req);
        @(posedge clk); #1;
        sb_q.push_back('{idx, e, req});
        cfg_idx = idx; rd_pend = 1'b1;
        @(posedge clk); #1;
        rd_pend = 1'b0;
    endtask

    task automatic pulse(input bit p, input bit s);
        @(posedge clk); #1;
        perr_evt = p; serr_evt = s;
        @(posedge clk); #1;
        perr_evt = 1'b0; serr_evt = 1'b0;
    endtask

    task automatic check_cmd(input logic [3:0] e, input string req);
        @(negedge clk);
        n_run++;
        if ({serr_en, parity_en, mem_en, io_en} !== e) begin
            n_fail++;
            $display("FAIL %s cmd outputs actual=%b expected=%b", req,
                     {serr_en, parity_en, mem_en, io_en}, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        cfg_read(8'd1, 32'h0000_0000, "R1");
        cfg_read(8'd4, 32'h0000_0000, "R1");
        cfg_read(8'd5, 32'h0000_0001, "R1");
        check_cmd(4'b0000, "R1");
        // R2 identity fields, read-only
        cfg_read(8'd0, 32'h0420_A5C3, "R2");
        cfg_write(8'd0, 32'hFFFF_FFFF, 4'h0);
        cfg_write(8'd2, 32'h0000_0000, 4'h0);
        cfg_read(8'd0, 32'h0420_A5C3, "R2");
        cfg_read(8'd2, 32'h1180_0003, "R2");
        // R3 writable Command bits and exported outputs
        cfg_write(8'd1, 32'h0000_FFFF, 4'h0);
        cfg_read(8'd1, 32'h0000_0547, "R3");
        check_cmd(4'b1111, "R3");
        // R4 byte enable: only byte 0 is written
        cfg_write(8'd1, 32'h0000_0000, 4'b1110);
        cfg_read(8'd1, 32'h0000_0500, "R4");
        check_cmd(4'b1000, "R4");
        // R5 error events set sticky bits
        pulse(1'b1, 1'b0);
        cfg_read(8'd1, 32'h8000_0500, "R5");
        pulse(1'b0, 1'b1);
        cfg_read(8'd1, 32'hC000_0500, "R5");
        // R6 write one to clear
        cfg_write(8'd1, 32'h4000_0500, 4'b0111);
        cfg_read(8'd1, 32'h8000_0500, "R6");
        cfg_write(8'd1, 32'h0000_0500, 4'b0111);
        cfg_read(8'd1, 32'h8000_0500, "R6");
        cfg_write(8'd1, 32'h8000_0500, 4'b1100);
        cfg_read(8'd1, 32'h8000_0500, "R6");
        cfg_write(8'd1, 32'h8000_0500, 4'b0111);
        cfg_read(8'd1, 32'h0000_0500, "R6");
        // R7 set event and clear in the same cycle
        pulse(1'b1, 1'b0);
        cfg_write(8'd1, 32'h8000_0500, 4'b0111, 1'b1);
        cfg_read(8'd1, 32'h8000_0500, "R7");
        // R8 memory BAR
        cfg_write(8'd4, 32'hFFFF_FFFF, 4'h0);
        cfg_read(8'd4, 32'hFFFF_F000, "R8");
        cfg_write(8'd4, 32'h1234_5678, 4'b0011);
        cfg_read(8'd4, 32'h1234_F000, "R8");
        // R9 I/O BAR
        cfg_write(8'd5, 32'hFFFF_FFFF, 4'h0);
        cfg_read(8'd5, 32'hFFFF_FFC1, "R9");
        // R10 unimplemented dwords
        cfg_write(8'd3, 32'hFFFF_FFFF, 4'h0);
        cfg_write(8'd255, 32'hFFFF_FFFF, 4'h0);
        cfg_read(8'd3, 32'h0000_0000, "R10");
        cfg_read(8'd255, 32'h0000_0000, "R10");
        cfg_read(8'd16, 32'h0000_0000, "R10");
        cfg_read(8'd4, 32'h1234_F000, "R10");
        // R11 no strobe, no change
        @(posedge clk); #1;
        cfg_idx = 8'd4; cfg_wdata = 32'h0; cfg_be_n = 4'h0;
        @(posedge clk); #1;
        cfg_idx = 8'd1;
        @(posedge clk); #1;
        cfg_be_n = 4'hF;
        cfg_read(8'd4, 32'h1234_F000, "R11");
        cfg_read(8'd1, 32'h8000_0500, "R11");
        // R12 same-cycle read after an index change
        @(posedge clk); #1;
        cfg_idx = 8'd5;
        #2;
        n_run++;
        if (cfg_rdata !== 32'hFFFF_FFC1) begin
            n_fail++;
            $display("FAIL R12 actual=%h expected=%h", cfg_rdata, 32'hFFFF_FFC1);
        end
        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL scoreboard actual=%0d expected=0 items left", sb_q.size());
        end
        finish_run();
    end

endmodule